// File: doc/BRIEF.md
# Instruction Decode and Control Generator

This block turns one fetched 16-bit instruction word and its program counter into a registered decode record for the execute stage. The record holds the ALU operation code, an immediate, the destination and source register indices with a valid flag for each, and the pipeline control bits. These control bits are writeback enable, writeback data select, memory access, memory write and ALU address select. A halt word is flagged. Where the register fields sit, and whether a source operand exists, depends on the upper opcode byte. There is no single fixed format.

Words enter on a valid/ready stream and leave on a second valid/ready stream through a one-deep output register. Back-pressure rules:
- A word is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output register is empty or being drained, unless `flush` is high.
- While `out_valid` is high and `out_ready` is low, the register holds its contents. This is the stall.
- `flush` drops the held record and accepts nothing in that cycle, so a squashed instruction reaches the execute stage as a bubble.

Top module: `instr_decoder`

## Requirements
- R1: `out_alu_op` equals instruction bits [15:8], and `out_pc` equals the program counter taken with the word.
- R2: A word whose bits [15:8] lie outside 0x10..0x7F has both `out_dst_vld` and `out_src_vld` low, and both indices read 0.
- R3: For an operand-bearing word, `out_dst` is bits [11:8] when bits [15:8] are in 0x40..0x5F, and bits [7:4] otherwise.
- R4: `out_src_vld` is high, with `out_src` equal to bits [3:0], exactly when the word is operand-bearing and its bits [15:8] are below 0x12, are in 0x16..0x22, equal 0x30, or are 0x60 or more. Otherwise `out_src` reads 0.
- R5: `out_wb_en` is high when bits [15:12] are 1 to 6 and bits [15:8] are not 0x16. `out_wb_mem` is high when bits [15:12] equal 6.
- R6: `out_mem_acc` is high when bits [15:13] equal 3. `out_mem_wr` and `out_addr_sel` are both high exactly when bits [15:12] equal 7.
- R7: `out_imm` is the zero-extended bits [7:0] when bits [15:13] equal 2, and the sign-extended bits [11:0] when bits [15:12] are 8 or more. Otherwise it is 0.
- R8: `out_halt` is high exactly for the word 0x0F00.
- R9: `in_ready` equals (not `out_valid` or `out_ready`) and not `flush`. After a transfer, `out_valid` is high at the next edge and shows the decode of the taken word.
- R10: While `out_valid` is high, `out_ready` is low and `flush` is low, the output record and `out_valid` do not change at the next edge.
- R11: `flush` makes `out_valid` low at the next edge.
- R12: During and after synchronous reset (`rst_n` low), `out_valid` is low until a word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Squash held record, take nothing this cycle |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Word accepted this cycle |
| in_instr | input | 16 | Instruction word |
| in_pc | input | 16 | Program counter of the word |
| out_valid | output | 1 | Decode record present |
| out_ready | input | 1 | Execute stage takes the record (low = stall) |
| out_pc | output | 16 | Program counter |
| out_alu_op | output | 8 | ALU operation code |
| out_imm | output | 16 | Immediate |
| out_dst | output | 4 | Destination register index |
| out_dst_vld | output | 1 | Destination index meaningful |
| out_src | output | 4 | Source register index |
| out_src_vld | output | 1 | Source index meaningful |
| out_wb_en | output | 1 | Writeback enable |
| out_wb_mem | output | 1 | Writeback takes memory data |
| out_mem_acc | output | 1 | Memory access |
| out_mem_wr | output | 1 | Memory write |
| out_addr_sel | output | 1 | ALU address select |
| out_halt | output | 1 | Halt word |

## Verification
The assertions take for granted that `rst_n` is held low across at least one rising edge before any traffic. They also assume `flush`, `in_valid` and `out_ready` are never unknown, since the hold and flush properties sample them on every edge. The stimulus drives every input to a defined value from time zero and keeps reset low for several edges. It then mixes stalls, flushes and idle input cycles freely, because any combination of these inputs is legal. The source and halt properties depend only on decode, so they hold for any instruction word, and the bench sweeps every opcode byte as well as random words.

// File: rtl/idec_pkg.sv
package idec_pkg;
  parameter int WORD_W = 16;
  parameter int PC_W   = 16;
  localparam int OP_W   = WORD_W / 2;
  localparam int RIDX_W = 4;
  localparam int SHORT_IMM_W = 8;
  localparam int LONG_IMM_W  = 12;
  localparam logic [WORD_W-1:0] HALT_WORD = 16'h0F00;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [OP_W-1:0]   alu_op;
    logic [WORD_W-1:0] imm;
    logic [RIDX_W-1:0] dst;
    logic              dst_vld;
    logic [RIDX_W-1:0] src;
    logic              src_vld;
    logic              wb_en;
    logic              wb_mem;
    logic              mem_acc;
    logic              mem_wr;
    logic              addr_sel;
    logic              halt;
  } idec_rec_t;
endpackage

// File: rtl/idec_regsel.sv
module idec_regsel
  import idec_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output logic [RIDX_W-1:0] dst,
  output logic              dst_vld,
  output logic [RIDX_W-1:0] src,
  output logic              src_vld
);
  logic [OP_W-1:0] op;
  logic            has_regs;
  logic            wide_dst;
  logic            needs_src;

  assign op = instr[WORD_W-1 -: OP_W];

  always_comb begin
    has_regs  = (op >= 8'h10) && (op <= 8'h7F);
    wide_dst  = (op[7:5] == 3'b010);
    needs_src = (op < 8'h12) || ((op >= 8'h16) && (op <= 8'h22)) ||
                (op == 8'h30) || (op >= 8'h60);
    dst_vld   = has_regs;
    src_vld   = has_regs && needs_src;
    dst       = '0;
    src       = '0;
    if (has_regs) dst = wide_dst ? instr[11:8] : instr[7:4];
    if (src_vld)  src = instr[RIDX_W-1:0];
  end
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output logic [OP_W-1:0]   alu_op,
  output logic [WORD_W-1:0] imm,
  output logic              wb_en,
  output logic              wb_mem,
  output logic              mem_acc,
  output logic              mem_wr,
  output logic              addr_sel,
  output logic              halt
);
  logic [3:0] cls;
  logic [2:0] grp;

  assign alu_op = instr[WORD_W-1 -: OP_W];
  assign cls    = instr[WORD_W-1 -: 4];
  assign grp    = instr[WORD_W-1 -: 3];

  always_comb begin
    wb_en    = (cls >= 4'd1) && (cls <= 4'd6) && (alu_op != 8'h16);
    wb_mem   = (cls == 4'd6);
    mem_acc  = (grp == 3'd3);
    mem_wr   = (cls == 4'd7);
    addr_sel = mem_wr;
    halt     = (instr == HALT_WORD);
    if (grp == 3'd2)
      imm = {{(WORD_W-SHORT_IMM_W){1'b0}}, instr[SHORT_IMM_W-1:0]};
    else if (cls >= 4'd8)
      imm = {{(WORD_W-LONG_IMM_W){instr[LONG_IMM_W-1]}}, instr[LONG_IMM_W-1:0]};
    else
      imm = '0;
  end

  always_comb begin
    if (mem_wr) assert_wr_implies_acc_R6: assert (mem_acc);
    if (halt)   assert_halt_no_wb_R8: assert (!wb_en && !mem_acc);
  end
endmodule

// File: rtl/idec_stage.sv
module idec_stage
  import idec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      in_valid,
  output logic      in_ready,
  input  idec_rec_t in_rec,
  output logic      out_valid,
  input  logic      out_ready,
  output idec_rec_t out_rec
);
  logic drain;

  assign drain    = !out_valid || out_ready;
  assign in_ready = drain && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rec   <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (drain) begin
      out_valid <= in_valid;
      if (in_valid) out_rec <= in_rec;
    end
  end

  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_rec)));
  assert_take_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_rec == $past(in_rec)));
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_instr,
  input  logic [PC_W-1:0]     in_pc,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PC_W-1:0]     out_pc,
  output logic [OP_W-1:0]     out_alu_op,
  output logic [WORD_W-1:0]   out_imm,
  output logic [RIDX_W-1:0]   out_dst,
  output logic                out_dst_vld,
  output logic [RIDX_W-1:0]   out_src,
  output logic                out_src_vld,
  output logic                out_wb_en,
  output logic                out_wb_mem,
  output logic                out_mem_acc,
  output logic                out_mem_wr,
  output logic                out_addr_sel,
  output logic                out_halt
);
  idec_rec_t dec_rec;
  idec_rec_t held_rec;

  assign dec_rec.pc = in_pc;

  idec_regsel u_regsel (
    .instr   (in_instr),
    .dst     (dec_rec.dst),
    .dst_vld (dec_rec.dst_vld),
    .src     (dec_rec.src),
    .src_vld (dec_rec.src_vld)
  );

  idec_ctrl u_ctrl (
    .instr    (in_instr),
    .alu_op   (dec_rec.alu_op),
    .imm      (dec_rec.imm),
    .wb_en    (dec_rec.wb_en),
    .wb_mem   (dec_rec.wb_mem),
    .mem_acc  (dec_rec.mem_acc),
    .mem_wr   (dec_rec.mem_wr),
    .addr_sel (dec_rec.addr_sel),
    .halt     (dec_rec.halt)
  );

  idec_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_rec    (dec_rec),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rec   (held_rec)
  );

  assign out_pc       = held_rec.pc;
  assign out_alu_op   = held_rec.alu_op;
  assign out_imm      = held_rec.imm;
  assign out_dst      = held_rec.dst;
  assign out_dst_vld  = held_rec.dst_vld;
  assign out_src      = held_rec.src;
  assign out_src_vld  = held_rec.src_vld;
  assign out_wb_en    = held_rec.wb_en;
  assign out_wb_mem   = held_rec.wb_mem;
  assign out_mem_acc  = held_rec.mem_acc;
  assign out_mem_wr   = held_rec.mem_wr;
  assign out_addr_sel = held_rec.addr_sel;
  assign out_halt     = held_rec.halt;

  assert_src_needs_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_src_vld) |-> out_dst_vld);
  assert_wbmem_is_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wb_mem) |-> (out_mem_acc && out_wb_en));
  assert_halt_has_no_regs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_halt) |-> (!out_dst_vld && !out_src_vld));
endmodule

// File: tb/instr_decoder_tb.sv
module instr_decoder_tb;
  import idec_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [15:0] in_instr = '0;
  logic [15:0] in_pc = '0;
  logic in_ready, out_valid;
  logic [15:0] out_pc, out_imm;
  logic [7:0] out_alu_op;
  logic [3:0] out_dst, out_src;
  logic out_dst_vld, out_src_vld, out_wb_en, out_wb_mem, out_mem_acc;
  logic out_mem_wr, out_addr_sel, out_halt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  instr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_instr(in_instr), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
    .out_alu_op(out_alu_op), .out_imm(out_imm), .out_dst(out_dst),
    .out_dst_vld(out_dst_vld), .out_src(out_src), .out_src_vld(out_src_vld),
    .out_wb_en(out_wb_en), .out_wb_mem(out_wb_mem), .out_mem_acc(out_mem_acc),
    .out_mem_wr(out_mem_wr), .out_addr_sel(out_addr_sel), .out_halt(out_halt)
  );

  // reference model state
  bit m_v = 0;
  int m_word = 0;
  int m_pc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_outputs();
    int w, op, cls, e_dst, e_src, e_imm;
    bit regs, e_dv, e_sv;
    chk(out_valid == m_v, "R9/R10/R11/R12 out_valid", int'(out_valid), int'(m_v));
    if (!m_v || !out_valid) return;
    w = m_word; op = w / 256; cls = w / 4096;
    regs = (op >= 16 && op <= 127);
    e_dv = regs;
    e_dst = 0;
    if (regs) e_dst = (op >= 64 && op <= 95) ? (op % 16) : ((w / 16) % 16);
    e_sv = regs && (op < 18 || (op >= 22 && op <= 34) || op == 48 || op >= 96);
    e_src = e_sv ? (w % 16) : 0;
    if (w / 8192 == 2) e_imm = w % 256;
    else if (cls >= 8) begin
      e_imm = w % 4096;
      if (e_imm >= 2048) e_imm = e_imm + 61440;
    end else e_imm = 0;
    chk(int'(out_alu_op) == op, "R1 alu_op", int'(out_alu_op), op);
    chk(int'(out_pc) == m_pc, "R1 pc", int'(out_pc), m_pc);
    chk(out_dst_vld == e_dv && int'(out_dst) == e_dst, "R2/R3 dst",
        int'({out_dst_vld, out_dst}), e_dv * 16 + e_dst);
    chk(out_src_vld == e_sv && int'(out_src) == e_src, "R2/R4 src",
        int'({out_src_vld, out_src}), e_sv * 16 + e_src);
    chk(out_wb_en == (cls >= 1 && cls <= 6 && op != 22), "R5 wb_en",
        int'(out_wb_en), int'(cls >= 1 && cls <= 6 && op != 22));
    chk(out_wb_mem == (cls == 6), "R5 wb_mem", int'(out_wb_mem), int'(cls == 6));
    chk(out_mem_acc == (w / 8192 == 3), "R6 mem_acc", int'(out_mem_acc), int'(w / 8192 == 3));
    chk(out_mem_wr == (cls == 7) && out_addr_sel == (cls == 7), "R6 mem_wr/addr_sel",
        int'({out_mem_wr, out_addr_sel}), (cls == 7) ? 3 : 0);
    chk(int'(out_imm) == e_imm, "R7 imm", int'(out_imm), e_imm);
    chk(out_halt == (w == 3840), "R8 halt", int'(out_halt), int'(w == 3840));
  endtask

  // one cycle: compare, drive, check ready, advance model
  task automatic step(input bit v, input int word, input bit rdy, input bit fl);
    bit e_rdy;
    @(negedge clk);
    compare_outputs();
    in_valid = v; in_instr = word[15:0]; in_pc = $urandom_range(0, 65535);
    out_ready = rdy; flush = fl;
    #1;
    e_rdy = (!m_v || rdy) && !fl;
    chk(in_ready == e_rdy, "R9 in_ready", int'(in_ready), int'(e_rdy));
    @(posedge clk);
    #1;
    if (fl) m_v = 0;
    else if (e_rdy) begin
      m_v = v;
      if (v) begin m_word = word; m_pc = int'(in_pc); end
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    // every opcode byte, streaming with no back-pressure
    for (int op = 0; op < 256; op++) begin
      step(1, op * 256 + ((op == 15) ? 0 : $urandom_range(0, 255)), 1, 0);
    end
    step(1, 16'h0F01, 1, 0);                 // R8 near-halt
    step(1, 16'h0F00, 1, 0);                 // R8 halt
    step(1, 16'h8800, 1, 0);                 // R7 negative long immediate
    step(1, 16'h47FF, 1, 0);                 // R3/R7 wide dst, short imm
    step(1, 16'h1234, 0, 0);                 // R10 stall begins
    step(1, 16'h7777, 0, 0);                 // R10 held
    step(1, 16'h6555, 0, 1);                 // R11 flush while stalled
    step(0, 0, 1, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 65535),
           $urandom_range(0, 2) != 0, $urandom_range(0, 9) == 0);
    end
    step(0, 0, 1, 0);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule